// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver

This block turns an asynchronous serial line into bytes. A frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. The block runs on the system clock. A one-cycle sample tick, supplied from outside at sixteen times the bit rate, gates all of its progress: for example 153,600 ticks per second for 9,600 baud. Clock cycles without a tick change nothing.

The block confirms a start bit by counting low samples up to the middle of the bit. From then on it samples every sixteen ticks, which puts each sample at the centre of a data bit and then at the centre of the stop bit. A good stop bit produces a one-cycle valid strobe. A bad stop bit loads all ones into the data register and raises a frame error flag. That flag stays up until the next start bit is confirmed. Every path back to idle clears the tick counter, so an error cannot leave the receiver stuck.

Top module: `uart_rx_os`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `data_o` is 0, `frame_err_o` is 0 and `valid_o` is 0, and the receiver waits for a start bit.
- R2: On clock cycles where `tick_i` is low, the receiver ignores `rxd_i` completely and its state does not advance.
- R3: A start bit is confirmed on the 8th consecutive tick with `rxd_i` low. A tick with `rxd_i` high before that point resets the low count to zero, so short low pulses start no frame.
- R4: After confirmation, data bit n (n = 0..7) is sampled on the 16·(n+1)-th tick and written to `data_o[n]`, least significant bit first.
- R5: The stop bit is sampled on the 16th tick after bit 7 is sampled. If `rxd_i` is high there, `valid_o` pulses and `data_o` holds the received byte.
- R6: If `rxd_i` is low at the stop sample, `data_o` becomes 8'hFF, `frame_err_o` becomes 1, and `valid_o` stays low.
- R7: `frame_err_o` keeps its value through idle and clears on the tick that confirms the next start bit.
- R8: After a bad frame, the receiver returns to idle with its tick counter cleared, and the next frame is received correctly.
- R9: `valid_o` is high for exactly one clock cycle per good frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sample enable, 16 per bit time |
| rxd_i | input | 1 | Serial line, idle high |
| data_o | output | 8 | Received byte, or 8'hFF after a framing error |
| frame_err_o | output | 1 | Bad stop bit seen on the last frame |
| valid_o | output | 1 | One-cycle strobe for a good frame |

## Verification
On every clock cycle without a tick, the bench drives the line to the opposite of the current bit. A receiver that samples without a tick therefore reads the wrong bits or confirms false starts. Low pulses of seven ticks, repeated and separated by one high tick, catch a low count that is not reset: such a design assembles a phantom frame and strobes valid. Bad stop bits are followed straight away by good frames. This exposes a counter left over from the error path, which shifts the sample points or locks the receiver up, and an error flag that clears too early or never clears. A reset in the middle of a frame checks that no part of the old frame survives.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_DATA  = 2'd1,
    ST_STOP  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rx_tick_cnt.sv
module rx_tick_cnt #(
  parameter int OVS   = 16,
  parameter int CNT_W = $clog2(OVS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic mid_o,
  output logic full_o
);
  logic [CNT_W-1:0] cnt_q;

  // mid: this tick is the (OVS/2)-th, full: this tick is the OVS-th
  assign mid_o  = (cnt_q == CNT_W'(OVS/2 - 1));
  assign full_o = (cnt_q == CNT_W'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= clr_i ? '0 : cnt_q + 1'b1;
  end

  p_hold_off_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && full_o) |=> (cnt_q == '0));
endmodule

// File: rtl/rx_data_reg.sv
module rx_data_reg #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              bit_i,
  input  logic              fill_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_o <= '0;
    else if (fill_i) data_o <= '1;
    else if (wr_i)   data_o[idx_i] <= bit_i;
  end

  p_wr_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && fill_i));
endmodule

// File: rtl/rx_fsm.sv
module rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rxd_i,
  input  logic             mid_i,
  input  logic             full_i,
  output logic             clr_o,
  output logic             wr_o,
  output logic             fill_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             err_o,
  output logic             valid_o
);
  rx_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             err_q, valid_q;
  logic             in_start;

  assign in_start = (state_q == ST_START);
  // clear on a high line or a confirmed start while idle, and on every 16th tick otherwise
  assign clr_o  = tick_i & (in_start ? (rxd_i | mid_i) : full_i);
  assign wr_o   = tick_i & (state_q == ST_DATA) & full_i;
  assign fill_o = tick_i & (state_q == ST_STOP) & full_i & ~rxd_i;
  assign idx_o  = idx_q;
  assign err_o  = err_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_START;
      idx_q   <= '0;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_START: if (!rxd_i && mid_i) begin
            state_q <= ST_DATA;
            idx_q   <= '0;
            err_q   <= 1'b0;
          end
          ST_DATA: if (full_i) begin
            if (idx_q == IDX_W'(DATA_W - 1)) begin
              idx_q   <= '0;
              state_q <= ST_STOP;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          ST_STOP: if (full_i) begin
            state_q <= ST_START;
            if (rxd_i) valid_q <= 1'b1;
            else       err_q   <= 1'b1;
          end
          default: state_q <= ST_START;
        endcase
      end
    end
  end

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  p_fill_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o |=> (err_q && !valid_q && state_q == ST_START));
  p_err_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_q) |-> (state_q == ST_DATA));
  p_state_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(state_q) && $stable(idx_q)));
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o,
  output logic              valid_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);

  logic             clr, mid, full, wr, fill;
  logic [IDX_W-1:0] idx;

  rx_tick_cnt #(.OVS(OVS), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .clr_i(clr), .mid_o(mid), .full_o(full)
  );

  rx_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk_i, .rst_ni, .tick_i, .rxd_i, .mid_i(mid), .full_i(full),
    .clr_o(clr), .wr_o(wr), .fill_o(fill), .idx_o(idx),
    .err_o(frame_err_o), .valid_o(valid_o)
  );

  rx_data_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_data (
    .clk_i, .rst_ni, .wr_i(wr), .idx_i(idx), .bit_i(rxd_i),
    .fill_i(fill), .data_o(data_o)
  );

  p_bad_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_err_o) |-> (data_o == '1));
  p_valid_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !frame_err_o);
endmodule

// File: tb/sim_uart_rx_os.sv
module sim_uart_rx_os;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic [7:0] data_o;
  logic       frame_err_o, valid_o;

  int checks = 0, errors = 0, vcnt = 0, cyc = 0;
  logic exp_err = 1'b0;

  always #10 clk_i = ~clk_i;

  uart_rx_os u0 (.clk_i, .rst_ni, .tick_i, .rxd_i, .data_o, .frame_err_o, .valid_o);

  // {stop_ok, byte}
  localparam logic [8:0] VEC [7] = '{
    {1'b1, 8'hA5}, {1'b1, 8'h00}, {1'b1, 8'hFF}, {1'b0, 8'h3C},
    {1'b1, 8'h81}, {1'b0, 8'h80}, {1'b1, 8'h01}
  };

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog act %0d exp <150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act %0h exp %0h", tag, act, exp);
    end
  endtask

  // one tick slot: line driven to the opposite level on cycles without a tick (R2)
  task automatic do_tick(input logic v);
    @(negedge clk_i); rxd_i = v; tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0; rxd_i = ~v;
    if (valid_o) vcnt = vcnt + 1;
    @(negedge clk_i);
    if (valid_o) vcnt = vcnt + 1;
    rxd_i = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic ok);
    vcnt = 0;
    repeat (4) do_tick(1'b1);
    repeat (7) do_tick(1'b0);
    chk("R7 err held before start confirm", 32'(frame_err_o), 32'(exp_err));
    do_tick(1'b0);
    chk("R3 R7 err cleared at 8th low tick", 32'(frame_err_o), 0);
    repeat (8) do_tick(1'b0);
    for (int n = 0; n < 8; n++) repeat (16) do_tick(b[n]);
    if (ok) repeat (16) do_tick(1'b1);
    else begin
      repeat (8) do_tick(1'b0);
      repeat (8) do_tick(1'b1);
    end
    repeat (6) do_tick(1'b1);
    exp_err = ~ok;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 data in reset", 32'(data_o), 0);
    chk("R1 err in reset", 32'(frame_err_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 data after reset", 32'(data_o), 0);
    chk("R1 valid after reset", 32'(valid_o), 0);

    for (int i = 0; i < 7; i++) begin
      send_frame(VEC[i][7:0], VEC[i][8]);
      if (VEC[i][8]) begin
        chk("R2 R4 R8 data", 32'(data_o), 32'(VEC[i][7:0]));
        chk("R5 err low", 32'(frame_err_o), 0);
        chk("R5 R9 one valid cycle", vcnt, 1);
      end else begin
        chk("R6 data forced ones", 32'(data_o), 32'hFF);
        chk("R6 err set", 32'(frame_err_o), 1);
        chk("R6 no valid", vcnt, 0);
      end
    end

    // glitch rejection: 7-low pulses must never add up to a start
    vcnt = 0;
    for (int g = 0; g < 3; g++) begin
      repeat (7) do_tick(1'b0);
      do_tick(1'b1);
    end
    repeat (200) do_tick(1'b1);
    chk("R3 glitch gives no valid", vcnt, 0);
    chk("R3 glitch leaves data", 32'(data_o), 32'h01);

    // reset in the middle of a frame
    repeat (16) do_tick(1'b0);
    repeat (40) do_tick(1'b0);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 mid-frame reset data", 32'(data_o), 0);
    chk("R1 mid-frame reset valid", 32'(valid_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    exp_err = 1'b0;
    send_frame(8'h5A, 1'b1);
    chk("R8 frame after reset", 32'(data_o), 32'h5A);
    chk("R9 valid after reset", vcnt, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule